// File: doc/BRIEF.md
# Convolutional Byte Deinterleaver

This block undoes a convolutional byte interleave applied to a stream of 204-byte frames (188 payload bytes followed by 16 parity bytes). Incoming bytes are dealt in turn across I branches, and each branch holds its bytes for a different number of visits. Branch j of the deinterleaver is a circular FIFO of (I-1-j)·M cells, where M = 204/I. This mirrors an interleaver whose branch j holds j·M cells. As a result, every byte spends the same total time in the pair, and the original frame order is restored.

The depth I can be changed at run time. It must be one of the divisors of 204 that do not exceed 12. All branch FIFOs share one on-chip array, and the per-branch start addresses and lengths are worked out whenever the depth is written. The first byte of each frame carries a sync marker. That marker forces the commutator back to branch 0, which is the branch paired with the interleaver's undelayed branch. The block is placed after frame synchronisation and ahead of the Reed-Solomon decoder.

Top module: `conv_deinterleaver`

## Requirements
- R1: After reset, out_valid, out_sync and cfg_err are low and the depth is 12, so a stream interleaved at depth 12 is recovered without any configuration write.
- R2: A cycle with cfg_write high and a legal cfg_depth (1, 2, 3, 4, 6 or 12) selects that depth for every byte accepted afterwards. It also empties all branches, so no data accepted before the write ever reaches the output.
- R3: A cfg_write with any other cfg_depth value (0, 5, 7 to 11, 13 to 15) leaves the active depth and the branch contents untouched, and sets cfg_err. cfg_err changes only on a cfg_write and is cleared by the next legal write.
- R4: Count accepted bytes from the most recent flush as n = 0, 1, 2, ... Assume the stream was produced by an interleaver that sends position n to branch n mod I, where branch j delays by j·M cells with M = 204/I and starts out holding zeros. Then the output sequence equals the original sequence.
- R5: out_valid rises exactly one clock after a cycle in which a byte was accepted (in_valid high, cfg_write low). It is never high in any other cycle.
- R6: After reset or a legal depth write, the first (I-1)·204 accepted bytes produce no output. From then on, every accepted byte produces exactly one output byte.
- R7: A byte accepted with in_sync high is routed through branch 0. out_sync is high on exactly those output bytes that were accepted with in_sync high, and these are the first bytes of the recovered frames.
- R8: Cycles with in_valid low advance no state: in_data and in_sync are ignored, and recovery continues unchanged across any pattern of idle cycles.
- R9: A byte presented in a cycle with cfg_write high is not accepted, whether or not the written depth is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_write | input | 1 | Depth write strobe |
| cfg_depth | input | 4 | Requested number of branches |
| cfg_err | output | 1 | Last depth write was illegal |
| in_valid | input | 1 | in_data holds a byte |
| in_data | input | 8 | Interleaved byte |
| in_sync | input | 1 | Byte is a frame start |
| out_valid | output | 1 | out_data holds a recovered byte |
| out_data | output | 8 | Deinterleaved byte |
| out_sync | output | 1 | Recovered byte is a frame start |

## Verification
A behavioural interleaver in the bench feeds every legal depth, and a scoreboard compares each recovered byte and its sync flag in order. A wrong branch length or base address would corrupt or reorder bytes. A fill count that is off by one would let zero-filled bytes through or swallow the first real one. Switching depth while the branches still hold stale data would expose a flush that fails to restart the pointers. Idle gaps that carry a raised in_sync and noise data would catch a commutator that moves without a valid byte. Illegal writes in the middle of a stream must leave the recovered data intact and raise cfg_err; a design that accepted the write would scramble the rest of the frame. A byte offered in the same cycle as a depth write must not produce an output.

// File: rtl/dintl_pkg.sv
`timescale 1ns / 1ps
package dintl_pkg;

    localparam int FRAME_LEN = 204;
    localparam int MAX_BR    = 12;
    localparam int DEPTH_W   = 4;
    localparam int BR_W      = $clog2(MAX_BR);
    localparam int MEM_WORDS = FRAME_LEN * (MAX_BR - 1) / 2;
    localparam int ADDR_W    = $clog2(MEM_WORDS);
    localparam int PTR_W     = $clog2(FRAME_LEN);
    localparam int FILL_W    = $clog2(FRAME_LEN * (MAX_BR - 1) + 1);
    localparam int RESET_DEPTH = MAX_BR;

    // configuration state: active depth plus derived branch layout
    typedef struct packed {
        logic [DEPTH_W-1:0]            depth;
        logic                          err;
        logic [MAX_BR-1:0][ADDR_W-1:0] base;
        logic [MAX_BR-1:0][PTR_W-1:0]  len;
        logic [FILL_W-1:0]             thr;
    } cfg_t;

    // commutator state: current branch, fill count, per-branch pointers
    typedef struct packed {
        logic [BR_W-1:0]               br;
        logic [FILL_W-1:0]             fill;
        logic [MAX_BR-1:0][PTR_W-1:0]  ptr;
    } sched_t;

    function automatic logic depth_legal(input logic [DEPTH_W-1:0] d);
        int di;
        di = int'(d);
        if (di < 1 || di > MAX_BR) return 1'b0;
        return (FRAME_LEN % di) == 0;
    endfunction

    // cells held by deinterleaver branch j at depth d
    function automatic int seg_len(input int d, input int j);
        if (d < 1 || j >= d - 1) return 0;
        return (d - 1 - j) * (FRAME_LEN / d);
    endfunction

    function automatic int seg_base(input int d, input int j);
        int acc;
        acc = 0;
        for (int k = 0; k < MAX_BR; k++) begin
            if (k < j) acc += seg_len(d, k);
        end
        return acc;
    endfunction

    function automatic cfg_t build_cfg(input logic [DEPTH_W-1:0] d, input logic err);
        cfg_t c;
        int   di;
        di      = int'(d);
        c.depth = d;
        c.err   = err;
        for (int j = 0; j < MAX_BR; j++) begin
            c.base[j] = ADDR_W'(seg_base(di, j));
            c.len[j]  = PTR_W'(seg_len(di, j));
        end
        c.thr = FILL_W'((di - 1) * FRAME_LEN);
        return c;
    endfunction

endpackage

// File: rtl/dintl_cfg.sv
`timescale 1ns / 1ps
module dintl_cfg
    import dintl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_write,
    input  logic [DEPTH_W-1:0]            cfg_depth,
    output logic [DEPTH_W-1:0]            depth,
    output logic                          cfg_err,
    output logic                          flush,
    output logic [MAX_BR-1:0][ADDR_W-1:0] br_base,
    output logic [MAX_BR-1:0][PTR_W-1:0]  br_len,
    output logic [FILL_W-1:0]             fill_thr
);

    cfg_t cfg_q, cfg_d;
    logic flush_d;

    always_comb begin
        cfg_d   = cfg_q;
        flush_d = 1'b0;
        if (cfg_write) begin
            if (depth_legal(cfg_depth)) begin
                cfg_d   = build_cfg(cfg_depth, 1'b0);
                flush_d = 1'b1;
            end else begin
                cfg_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= build_cfg(DEPTH_W'(RESET_DEPTH), 1'b0);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign flush    = flush_d;
    assign depth    = cfg_q.depth;
    assign cfg_err  = cfg_q.err;
    assign br_base  = cfg_q.base;
    assign br_len   = cfg_q.len;
    assign fill_thr = cfg_q.thr;

endmodule

// File: rtl/dintl_sched.sv
`timescale 1ns / 1ps
module dintl_sched
    import dintl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          accept,
    input  logic                          in_sync,
    input  logic [DEPTH_W-1:0]            depth,
    input  logic [MAX_BR-1:0][ADDR_W-1:0] br_base,
    input  logic [MAX_BR-1:0][PTR_W-1:0]  br_len,
    input  logic [FILL_W-1:0]             fill_thr,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          use_mem,
    output logic                          emit
);

    sched_t sch_q, sch_d;
    logic [BR_W-1:0]              sel;
    logic [DEPTH_W:0]             sel_inc;
    logic [MAX_BR-1:0][PTR_W-1:0] ptr_nx;

    // frame start always enters branch 0
    always_comb begin
        sel      = in_sync ? '0 : sch_q.br;
        use_mem  = br_len[sel] != '0;
        mem_addr = br_base[sel] + ADDR_W'(sch_q.ptr[sel]);
        mem_we   = accept && use_mem;
        emit     = accept && (sch_q.fill >= fill_thr);
        sel_inc  = (DEPTH_W + 1)'(sel) + 1'b1;
    end

    for (genvar j = 0; j < MAX_BR; j++) begin : g_ptr
        assign ptr_nx[j] = (mem_we && sel == BR_W'(j))
                         ? ((sch_q.ptr[j] + 1'b1 == br_len[j]) ? '0 : sch_q.ptr[j] + 1'b1)
                         : sch_q.ptr[j];
    end

    always_comb begin
        sch_d     = sch_q;
        sch_d.ptr = ptr_nx;
        if (accept) begin
            sch_d.br = (sel_inc == (DEPTH_W + 1)'(depth)) ? '0 : BR_W'(sel_inc);
            if (sch_q.fill < fill_thr) sch_d.fill = sch_q.fill + 1'b1;
        end
        if (flush) sch_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_q <= '0;
        end else begin
            sch_q <= sch_d;
        end
    end

endmodule

// File: rtl/dintl_store.sv
`timescale 1ns / 1ps
module dintl_store #(
    parameter int WORDS = 1122,
    parameter int AW    = 11,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [WORDS];

    // read-before-write: the cell leaving the FIFO is replaced by the new byte
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/conv_deinterleaver.sv
`timescale 1ns / 1ps
module conv_deinterleaver
    import dintl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_write,
    input  logic [DEPTH_W-1:0] cfg_depth,
    output logic               cfg_err,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_sync,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sync
);

    typedef struct packed {
        logic              valid;
        logic              sync;
        logic [DATA_W-1:0] data;
    } out_t;

    logic [DEPTH_W-1:0]            depth;
    logic                          flush;
    logic [MAX_BR-1:0][ADDR_W-1:0] br_base;
    logic [MAX_BR-1:0][PTR_W-1:0]  br_len;
    logic [FILL_W-1:0]             fill_thr;
    logic                          accept;
    logic                          mem_we;
    logic [ADDR_W-1:0]             mem_addr;
    logic                          use_mem;
    logic                          emit;
    logic [DATA_W-1:0]             rdata;
    out_t                          out_q, out_d;

    assign accept = in_valid && !cfg_write;

    dintl_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_write (cfg_write),
        .cfg_depth (cfg_depth),
        .depth     (depth),
        .cfg_err   (cfg_err),
        .flush     (flush),
        .br_base   (br_base),
        .br_len    (br_len),
        .fill_thr  (fill_thr)
    );

    dintl_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .accept   (accept),
        .in_sync  (in_sync),
        .depth    (depth),
        .br_base  (br_base),
        .br_len   (br_len),
        .fill_thr (fill_thr),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .use_mem  (use_mem),
        .emit     (emit)
    );

    dintl_store #(
        .WORDS (MEM_WORDS),
        .AW    (ADDR_W),
        .DW    (DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (in_data),
        .rdata (rdata)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = emit;
        out_d.sync  = emit && in_sync;
        if (emit) out_d.data = use_mem ? rdata : in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_sync  = out_q.sync;
    assign out_data  = out_q.data;

endmodule

// File: rtl/conv_deinterleaver_chk.sv
`timescale 1ns / 1ps
module conv_deinterleaver_chk
    import dintl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_write,
    input logic [DEPTH_W-1:0] cfg_depth,
    input logic               cfg_err,
    input logic               in_valid,
    input logic               in_sync,
    input logic               out_valid,
    input logic               out_sync
);

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !cfg_write)); // R5

    AST_SYNC_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_sync |-> (out_valid && $past(in_sync))); // R7

    AST_WRITE_CYCLE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_write) |-> !out_valid); // R9

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_write) |-> $stable(cfg_err)); // R3

    AST_ERR_CLEAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_err) |-> $past(cfg_write && depth_legal(cfg_depth))); // R3

    AST_ERR_SET_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_write && !depth_legal(cfg_depth)) |-> cfg_err); // R3

endmodule

bind conv_deinterleaver conv_deinterleaver_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_write (cfg_write),
    .cfg_depth (cfg_depth),
    .cfg_err   (cfg_err),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .out_valid (out_valid),
    .out_sync  (out_sync)
);

// File: tb/conv_deinterleaver_tb.sv
`timescale 1ns / 1ps
module conv_deinterleaver_tb;

    localparam int FRM = 204;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_write = 1'b0;
    logic [3:0] cfg_depth = 4'd0;
    logic       cfg_err;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_sync = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sync;

    typedef struct packed {
        logic [7:0] data;
        logic       sync;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    conv_deinterleaver u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_write (cfg_write),
        .cfg_depth (cfg_depth),
        .cfg_err   (cfg_err),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sync   (in_sync),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sync  (out_sync)
    );

    function automatic logic [7:0] src_byte(input int k, input int seed);
        if (k % FRM == 0) return 8'h47;
        return 8'((k * 37 + seed * 91 + (k >> 3) * 5) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R6: output %0h while nothing expected, expected no output", out_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R4 data", 32'(out_data), 32'(e.data));
                check("R7 sync flag", 32'(out_sync), 32'(e.sync));
            end
        end
    end

    // interleaver model: position n goes to branch n mod d, delayed j*M cells
    task automatic stream(input int d, input int seed, input int n0, input int n1, input int gap);
        int m;
        int thr;
        m   = FRM / d;
        thr = (d - 1) * FRM;
        for (int n = n0; n < n1; n++) begin
            int j;
            int src;
            j   = n % d;
            src = n - j * m * d;
            @(negedge clk);
            in_valid = 1'b1;
            in_sync  = (n % FRM) == 0;
            in_data  = (src >= 0) ? src_byte(src, seed) : 8'h00;
            if (n >= thr) sb.push_back({src_byte(n - thr, seed), ((n - thr) % FRM) == 0});
            if (gap > 0 && (n % gap) == gap - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sync  = 1'b1;   // R8: sync and data on an idle cycle are noise
                in_data  = 8'hA5;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sync  = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        check(tag, 32'(sb.size()), 32'd0);
        sb.delete();
    endtask

    task automatic set_depth(input int d, input logic with_byte);
        @(negedge clk);
        cfg_write = 1'b1;
        cfg_depth = 4'(d);
        in_valid  = with_byte;
        in_sync   = with_byte;
        in_data   = 8'h47;
        @(negedge clk);
        cfg_write = 1'b0;
        in_valid  = 1'b0;
        in_sync   = 1'b0;
        check("R9 no output for byte in write cycle", 32'(out_valid), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 out_sync after reset", 32'(out_sync), 32'd0);
        check("R1 cfg_err after reset", 32'(cfg_err), 32'd0);

        // R1: default depth 12 without a write
        stream(12, 1, 0, 13 * FRM, 0);
        drain("R1 default depth stream fully recovered");

        // R2: switch to 3 while branches hold stale data, with gaps (R8)
        set_depth(3, 1'b0);
        stream(3, 2, 0, 5 * FRM, 7);
        drain("R8 gapped stream fully recovered");

        // R9: byte offered in write cycle; R3 illegal writes mid stream
        set_depth(4, 1'b1);
        stream(4, 3, 0, 900, 0);
        set_depth(7, 1'b0);
        check("R3 error after depth 7", 32'(cfg_err), 32'd1);
        set_depth(13, 1'b0);
        check("R3 error after depth 13", 32'(cfg_err), 32'd1);
        stream(4, 3, 900, 9 * FRM, 5);
        drain("R3 depth kept after illegal write");
        set_depth(0, 1'b0);
        check("R3 error after depth 0", 32'(cfg_err), 32'd1);

        // depth 1: no fill, error cleared by a legal write
        set_depth(1, 1'b0);
        check("R3 error cleared by legal write", 32'(cfg_err), 32'd0);
        stream(1, 4, 0, 3 * FRM, 3);
        drain("R2 depth 1 stream recovered");

        // R5: one-clock latency on the last byte of a stream
        set_depth(6, 1'b0);
        stream(6, 5, 0, 8 * FRM, 0);
        check("R5 valid one clock after last byte", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R5 valid low after idle", 32'(out_valid), 32'd0);
        drain("R6 depth 6 fill and count");

        set_depth(2, 1'b0);
        stream(2, 6, 0, 4 * FRM, 4);
        drain("R2 depth 2 stream recovered");

        set_depth(12, 1'b0);
        stream(12, 7, 0, 12 * FRM + 17, 0);
        drain("R6 depth 12 after flush");

        report();
        $finish;
    end

endmodule